// File: doc/BRIEF.md
# Oversampling Serial Receiver With Error-Tagged FIFO

This block turns an asynchronous serial line back into characters. A one-cycle enable arrives at sixteen times the bit rate. When the line falls while the receiver is idle, the receiver counts eight enables to reach the middle of the start bit and checks the line again there. A start bit that has already gone high again is thrown away. A confirmed start leads to sampling of every data bit, the optional parity bit and the stop bit, each sixteen enables after the one before. Each finished character goes into a small queue. Every entry holds the byte and three tags: a parity mismatch, a low stop bit, and a line break.

The host sets the character length, parity and queue mode with static configuration inputs. It pops entries with a one-cycle read strobe while the data-available output is high. In buffered mode the queue holds up to sixteen entries. In single mode it behaves as one holding register. A character that completes while no room is left is dropped, and a sticky flag records it until the host acknowledges it.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset, data_avail and overrun are 0, and the receiver waits for a falling line.
- R2: The receiver checks the line 8 enables after it first sees it low. If the line is high at that check, the receiver returns to idle and stores no entry.
- R3: Data bits are taken least significant bit first, one every 16 enables after the start check. char_len codes 0, 1, 2 and 3 select 5, 6, 7 and 8 bits. Bits above the chosen length read as 0.
- R4: With par_en=1 one parity bit follows the data. With par_even=1 the data plus parity must hold an even number of ones, and with par_even=0 an odd number. A mismatch sets the entry's perr bit. With par_en=0, perr is 0.
- R5: A stop bit sampled low sets the entry's ferr bit.
- R6: If the start bit, all data bits, the parity bit (when enabled) and the stop bit are all low, exactly one entry is stored, with data 0x00, brk=1, ferr=1 and perr=0. No further frame starts until the line has been high on an enable.
- R7: With fifo_en=1, up to 16 entries are kept and read out in arrival order.
- R8: With fifo_en=0, only one entry is kept, and a second character arriving before a read causes an overrun.
- R9: A character that completes when the queue is full is discarded, and the stored entries are unchanged. overrun is set, stays set until an ovr_ack pulse, and a new overrun in the same cycle as the acknowledge wins.
- R10: rd_en pops the head entry when data_avail is 1. rd_en while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable pulse at sixteen times the bit rate |
| rxd | input | 1 | Serial input, synchronous to clk, idle high |
| char_len | input | 2 | Character length code (0..3 = 5..8 bits) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding entry |
| rd_en | input | 1 | Pop the head entry |
| ovr_ack | input | 1 | Clear the overrun flag |
| data_avail | output | 1 | Queue holds at least one entry |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry break |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench sends frames at 5, 6 and 8 bits, so that masking and bit order show up in the stored byte. It sends even and odd parity frames with the parity bit correct and with it inverted, which separates the two parity senses from a constant tag. Three patterns all hold the line low, but for different reasons: a short low pulse (must leave nothing stored), a frame with a low stop bit but non-zero data (framing error only), and a long all-low period (exactly one break entry, then a clean frame after it). Seventeen back-to-back frames in buffered mode and two in single mode show where overrun starts and that the entries already stored come out intact and in order.

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       fifo_en,
  input  logic       rd_en,
  input  logic       ovr_ack,
  output logic       data_avail,
  output logic [7:0] rd_data,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       rd_brk,
  output logic       overrun
);
  localparam int EW = 11;
  localparam logic [AW:0] CAP_BUF = DEPTH[AW:0];

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

  st_t         st;
  logic [3:0]  cnt;
  logic [2:0]  bidx;
  logic [7:0]  shreg;
  logic        par_bit;
  logic        all_zero;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count;

  wire         mid      = tick16 && (cnt == 4'd15);
  wire [2:0]   last_bit = 3'd4 + {1'b0, char_len};
  wire         exp_par  = par_even ? ^shreg : ~^shreg;
  wire         done     = (st == S_STOP) && mid;
  wire         is_brk   = all_zero && !rxd;
  wire         f_perr   = par_en && !is_brk && (par_bit != exp_par);
  wire [AW:0]  cap      = fifo_en ? CAP_BUF : {{AW{1'b0}}, 1'b1};
  wire         full     = count >= cap;
  wire         do_push  = done && !full;
  wire         do_pop   = rd_en && (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bidx     <= '0;
      shreg    <= '0;
      par_bit  <= 1'b0;
      all_zero <= 1'b0;
    end else if (tick16) begin
      cnt <= cnt + 4'd1;
      case (st)
        S_IDLE:
          if (!rxd) begin
            st  <= S_START;
            cnt <= '0;
          end
        S_START:
          if (cnt == 4'd7) begin
            cnt <= '0;
            if (rxd) st <= S_IDLE;
            else begin
              st       <= S_DATA;
              bidx     <= '0;
              shreg    <= '0;
              all_zero <= 1'b1;
            end
          end
        S_DATA:
          if (mid) begin
            shreg[bidx] <= rxd;
            if (rxd) all_zero <= 1'b0;
            if (bidx == last_bit) st <= par_en ? S_PAR : S_STOP;
            else bidx <= bidx + 3'd1;
          end
        S_PAR:
          if (mid) begin
            par_bit <= rxd;
            if (rxd) all_zero <= 1'b0;
            st <= S_STOP;
          end
        S_STOP:
          if (mid) st <= is_brk ? S_HOLD : S_IDLE;
        S_HOLD:
          if (rxd) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= {is_brk, !rxd, f_perr, is_brk ? 8'h00 : shreg};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (done && full) overrun <= 1'b1;
      else if (ovr_ack) overrun <= 1'b0;
    end
  end

  assign data_avail = (count != '0);
  assign {rd_brk, rd_ferr, rd_perr, rd_data} = mem[rp];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP_BUF) else $error("queue count above depth"); // R7
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full && !rd_en) |=> (count == $past(count) && wp == $past(wp))) else $error("overrun changed queue"); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_ack) |=> overrun) else $error("overrun flag lost"); // R9
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !data_avail && !done) |=> (rp == $past(rp) && !data_avail)) else $error("empty read moved pointer"); // R10
  AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && tick16 && cnt == 4'd7 && rxd) |=> (st == S_IDLE && count == $past(count) - {{AW{1'b0}}, $past(do_pop)})) else $error("false start not rejected"); // R2
  AST_BRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && !(tick16 && rxd)) |=> st == S_HOLD) else $error("left break wait early"); // R6
  AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && count >= 1 && !do_pop) |=> count == $past(count)) else $error("single mode grew"); // R8
endmodule

// File: tb/serial_rx_fifo_tb.sv
module serial_rx_fifo_tb_top;
  logic clk = 0, rst_n = 0, tick16 = 0, rxd = 1;
  logic [1:0] char_len = 2'd3;
  logic par_en = 0, par_even = 0, fifo_en = 1, rd_en = 0, ovr_ack = 0;
  logic data_avail, rd_perr, rd_ferr, rd_brk, overrun;
  logic [7:0] rd_data;

  int checks = 0, errors = 0, ph = 0;
  logic [10:0] exp_q[$];
  bit ovr_m = 0;

  always #4 clk = ~clk;

  serial_rx_fifo dut_i (.clk, .rst_n, .tick16, .rxd, .char_len, .par_en, .par_even,
    .fifo_en, .rd_en, .ovr_ack, .data_avail, .rd_data, .rd_perr, .rd_ferr, .rd_brk, .overrun);

  always @(negedge clk) begin
    ph = (ph + 1) % 4;
    tick16 <= (ph == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  function automatic int cap_m();
    return fifo_en ? 16 : 1;
  endfunction

  task automatic model_push(input logic [10:0] e);
    if (exp_q.size() >= cap_m()) ovr_m = 1;
    else exp_q.push_back(e);
  endtask

  task automatic send(input logic [7:0] d, input bit pflip, input bit stop_v);
    int nb = 5 + char_len;
    logic [7:0] dm = d & 8'((1 << nb) - 1);
    logic p = (par_even ? ^dm : ~^dm) ^ pflip;
    rxd = 0; hold(16);
    for (int i = 0; i < nb; i++) begin rxd = dm[i]; hold(16); end
    if (par_en) begin rxd = p; hold(16); end
    rxd = stop_v;
    if (stop_v) hold(16); else begin hold(10); rxd = 1; hold(16); end
    hold(2);
    model_push({1'b0, !stop_v, par_en & pflip, dm});
  endtask

  task automatic read_chk(input string req);
    logic [10:0] e;
    if (exp_q.size() == 0) begin chk(0, req, 0, 1); return; end
    e = exp_q.pop_front();
    chk(data_avail === 1'b1, req, data_avail, 1);
    chk({rd_brk, rd_ferr, rd_perr, rd_data} === e, req, {rd_brk, rd_ferr, rd_perr, rd_data}, e);
    rd_en = 1; @(negedge clk); rd_en = 0; @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk(data_avail === 1'b0, "R1 avail", data_avail, 0);
    chk(overrun === 1'b0, "R1 overrun", overrun, 0);
    hold(4);

    send(8'hA5, 0, 1); read_chk("R3 8-bit");
    char_len = 2'd0; send(8'hFF, 0, 1); read_chk("R3 5-bit mask");
    char_len = 2'd1; send(8'h2A, 0, 1); read_chk("R3 6-bit");
    char_len = 2'd3; par_en = 1; par_even = 1;
    send(8'h37, 0, 1); read_chk("R4 even ok");
    send(8'h37, 1, 1); read_chk("R4 even bad");
    par_even = 0;
    send(8'h01, 0, 1); read_chk("R4 odd ok");
    send(8'hC3, 1, 1); read_chk("R4 odd bad");
    par_en = 0;
    send(8'h55, 0, 0); read_chk("R5 framing");

    rxd = 0; hold(3); rxd = 1; hold(40);
    chk(data_avail === 1'b0, "R2 false start", data_avail, 0);

    rxd = 0; hold(16 * 13); rxd = 1; hold(16);
    model_push({1'b1, 1'b1, 1'b0, 8'h00});
    read_chk("R6 break entry");
    chk(data_avail === 1'b0, "R6 single break", data_avail, 0);
    send(8'h0F, 0, 1); read_chk("R6 after break");

    rd_en = 1; @(negedge clk); rd_en = 0; @(negedge clk);
    chk(data_avail === 1'b0, "R10 empty read", data_avail, 0);
    send(8'h3C, 0, 1); read_chk("R10 after empty read");
    chk(data_avail === 1'b0, "R10 drained", data_avail, 0);

    for (int k = 0; k < 17; k++) send(8'(8'h10 + k), 0, 1);
    chk(overrun === ovr_m, "R9 overrun set", overrun, ovr_m);
    for (int k = 0; k < 16; k++) read_chk("R7 order");
    chk(data_avail === 1'b0, "R9 dropped char", data_avail, 0);
    chk(overrun === 1'b1, "R9 sticky", overrun, 1);
    ovr_ack = 1; @(negedge clk); ovr_ack = 0; @(negedge clk); ovr_m = 0;
    chk(overrun === 1'b0, "R9 cleared", overrun, 0);

    fifo_en = 0;
    send(8'h81, 0, 1); send(8'h82, 0, 1);
    chk(overrun === 1'b1, "R8 overrun", overrun, 1);
    read_chk("R8 first kept");
    chk(data_avail === 1'b0, "R8 one entry", data_avail, 0);

    finish_run();
  end
endmodule